// File: doc/BRIEF.md
# Capture-Aware Overflow Timer

An 8-bit up-counter, stepped by one of four taps of a free-running prescaler, with one 8-bit mode register behind a simple register read/write port. The mode register selects the counting rate and the capture-input edges that reset the counter to zero. It also selects which edge of the capture input raises a one-cycle capture interrupt, and it gates an overflow interrupt.

When the counter steps from 0xFF to 0x00, one of two overflow flags is raised. The high-level flag records wraps that happen while the capture input is 1. The low-level flag records wraps that happen while the capture input is 0, and every wrap when the counter runs free with no clear source selected. Software clears a flag in two steps: a register read must return the flag as 1, and a later write of 0 to it then clears it. Software can never set a flag.

Register port: `reg_addr` 0 is the mode register and `reg_addr` 1 is the counter. Mode register layout: bit 7 is the high-level flag and bit 6 is the low-level flag. Bit 5 is the overflow interrupt enable. Bit 4 selects the capture interrupt edge (1 = rising, 0 = falling). Bits 3:2 are the clear select and bits 1:0 are the rate select.

Top module: `cap_timer`

## Requirements
- R1: After reset, the mode register reads 0x00, the counter reads 0x00, and both interrupt outputs are 0.
- R2: Rate select bits 1:0 step the counter once every 64 (00), 32 (01), 4 (10) or 2 (11) clock cycles. Any window of N×divisor consecutive cycles therefore adds exactly N.
- R3: When the counter wraps from 0xFF to 0x00 with the capture input at 1 and clear select not 00, bit 7 is set and bit 6 is not.
- R4: Bit 6 is set on a wrap with the capture input at 0. It is also set on any wrap while clear select is 00 (free-running mode), and in that mode bit 7 is not set.
- R5: A flag clears only when a write of 0 to its bit follows a register read that returned that bit as 1. A write of 0 with no such read leaves the flag at 1.
- R6: Writing 1 to bit 7 or bit 6 never sets the flag.
- R7: If a wrap sets a flag in the same cycle that a valid clear write targets it, the flag ends at 1.
- R8: Clear select bits 3:2 reset the counter to 0 on the next clock edge: 00 never, 01 on a falling capture-input edge, 10 on a rising edge, 11 on either edge.
- R9: `cap_irq` is 1 for the one cycle in which the capture input differs from its value at the previous clock edge, in the direction chosen by bit 4.
- R10: `ovf_irq` is 1 exactly while bit 5 is 1 and at least one flag is 1.
- R11: A write to address 1 loads the counter on the next edge. This load takes precedence over a clear or a step in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_in | input | 1 | Capture input, synchronous to clk |
| reg_rd | input | 1 | Read strobe; a read of address 0 arms the flags that read as 1 |
| reg_wr | input | 1 | Write strobe |
| reg_addr | input | 1 | 0 = mode register, 1 = counter |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| ovf_irq | output | 1 | Overflow interrupt request |
| cap_irq | output | 1 | Capture edge interrupt pulse |

## Verification
A wrong arm bit shows at the next write of 0 to the mode register. Either the flag survives a legitimate clear, or it drops without a prior read, and both are visible on `reg_rdata` and `ovf_irq` one cycle later. A wrong prescaler tap shifts the count after a single window of N×divisor cycles. A wrong level-to-flag routing shows at the first wrap as the wrong bit of 7:6. A wrong clear decode leaves the counter non-zero one cycle after the chosen edge.

// File: rtl/cap_timer_pkg.sv
package cap_timer_pkg;

    localparam int CNT_W  = 8;
    localparam int PRE_W  = 6;
    localparam int CTL_W  = 6;
    localparam int NFLAG  = 2;
    localparam int FLAG_LO = CTL_W;

    typedef enum logic [1:0] {
        RATE_DIV64 = 2'b00,
        RATE_DIV32 = 2'b01,
        RATE_DIV4  = 2'b10,
        RATE_DIV2  = 2'b11
    } rate_sel_e;

    typedef enum logic [1:0] {
        CLR_NONE = 2'b00,
        CLR_FALL = 2'b01,
        CLR_RISE = 2'b10,
        CLR_BOTH = 2'b11
    } clr_sel_e;

    typedef struct packed {
        logic      ovf_ie;
        logic      edge_rise;
        clr_sel_e  clr_sel;
        rate_sel_e rate_sel;
    } mode_ctl_t;

    // Prescaler bits that must all be 1 for a step at the selected rate.
    function automatic logic [PRE_W-1:0] rate_mask(rate_sel_e sel);
        case (sel)
            RATE_DIV64: rate_mask = PRE_W'(63);
            RATE_DIV32: rate_mask = PRE_W'(31);
            RATE_DIV4:  rate_mask = PRE_W'(3);
            default:    rate_mask = PRE_W'(1);
        endcase
    endfunction

endpackage

// File: rtl/cap_timer_pre.sv
module cap_timer_pre
    import cap_timer_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  rate_sel_e sel,
    output logic      tick
);
    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] mask;

    always_ff @(posedge clk) begin
        if (rst) pre_q <= '0;
        else     pre_q <= pre_q + PRE_W'(1);
    end

    assign mask = rate_mask(sel);
    assign tick = ((pre_q & mask) == mask);
endmodule

// File: rtl/cap_timer_edge.sv
module cap_timer_edge (
    input  logic clk,
    input  logic rst,
    input  logic cap_in,
    output logic cap_q,
    output logic rise,
    output logic fall
);
    always_ff @(posedge clk) begin
        if (rst) cap_q <= 1'b0;
        else     cap_q <= cap_in;
    end

    assign rise = cap_in & ~cap_q;
    assign fall = ~cap_in & cap_q;
endmodule

// File: rtl/cap_timer_flag.sv
module cap_timer_flag (
    input  logic clk,
    input  logic rst,
    input  logic hw_set,
    input  logic rd_hit,
    input  logic wr_hit,
    input  logic wr_bit,
    output logic flag
);
    logic armed_q;
    logic clr_req;

    assign clr_req = wr_hit & ~wr_bit & armed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag    <= 1'b0;
            armed_q <= 1'b0;
        end else begin
            if (hw_set)       flag <= 1'b1;
            else if (clr_req) flag <= 1'b0;

            if (clr_req)            armed_q <= 1'b0;
            else if (rd_hit & flag) armed_q <= 1'b1;
        end
    end
endmodule

// File: rtl/cap_timer.sv
module cap_timer
    import cap_timer_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cap_in,
    input  logic             reg_rd,
    input  logic             reg_wr,
    input  logic             reg_addr,
    input  logic [7:0]       reg_wdata,
    output logic [7:0]       reg_rdata,
    output logic             ovf_irq,
    output logic             cap_irq
);
    localparam logic [CNT_W-1:0] CNT_TOP = '1;

    mode_ctl_t        ctl_q;
    logic [CNT_W-1:0] cnt_q;
    logic [NFLAG-1:0] ovf_flag;
    logic [NFLAG-1:0] hw_set;
    logic             tick, cap_q, rise, fall;
    logic             wr_mode, wr_cnt, rd_mode;
    logic             clr_hit, free_run, wrap;

    assign wr_mode = reg_wr & ~reg_addr;
    assign wr_cnt  = reg_wr &  reg_addr;
    assign rd_mode = reg_rd & ~reg_addr;

    cap_timer_pre u_pre (
        .clk  (clk),
        .rst  (rst),
        .sel  (ctl_q.rate_sel),
        .tick (tick)
    );

    cap_timer_edge u_edge (
        .clk    (clk),
        .rst    (rst),
        .cap_in (cap_in),
        .cap_q  (cap_q),
        .rise   (rise),
        .fall   (fall)
    );

    always_comb begin
        case (ctl_q.clr_sel)
            CLR_FALL: clr_hit = fall;
            CLR_RISE: clr_hit = rise;
            CLR_BOTH: clr_hit = rise | fall;
            default:  clr_hit = 1'b0;
        endcase
    end

    assign free_run = (ctl_q.clr_sel == CLR_NONE);
    assign wrap     = tick & (cnt_q == CNT_TOP) & ~clr_hit & ~wr_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
            cnt_q <= '0;
        end else begin
            if (wr_mode) ctl_q <= mode_ctl_t'(reg_wdata[CTL_W-1:0]);
            if (wr_cnt)       cnt_q <= reg_wdata[CNT_W-1:0];
            else if (clr_hit) cnt_q <= '0;
            else if (tick)    cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    // index 1: high-level flag (bit 7), index 0: low-level flag (bit 6)
    assign hw_set[1] = wrap &  cap_in & ~free_run;
    assign hw_set[0] = wrap & (~cap_in | free_run);

    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
        cap_timer_flag u_flag (
            .clk    (clk),
            .rst    (rst),
            .hw_set (hw_set[i]),
            .rd_hit (rd_mode),
            .wr_hit (wr_mode),
            .wr_bit (reg_wdata[FLAG_LO+i]),
            .flag   (ovf_flag[i])
        );
    end

    assign reg_rdata = reg_addr ? cnt_q : {ovf_flag, ctl_q};
    assign ovf_irq   = ctl_q.ovf_ie & (|ovf_flag);
    assign cap_irq   = ctl_q.edge_rise ? rise : fall;
endmodule

// File: rtl/cap_timer_chk.sv
module cap_timer_chk (
    input logic       clk,
    input logic       rst,
    input logic       cap_in,
    input logic       cap_q,
    input logic       reg_wr,
    input logic       reg_addr,
    input logic [7:0] reg_wdata,
    input logic [7:0] cnt_q,
    input logic [1:0] ovf_flag,
    input logic [5:0] ctl_bits,
    input logic       cap_irq
);
    assert_flag_h_wrap_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf_flag[1]) |-> ($past(cnt_q) == 8'hFF && $past(cap_in) && $past(ctl_bits[3:2]) != 2'b00));

    assert_flag_l_wrap_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf_flag[0]) |-> ($past(cnt_q) == 8'hFF && (!$past(cap_in) || $past(ctl_bits[3:2]) == 2'b00)));

    assert_flag_clear_by_write_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(ovf_flag[1]) |-> $past(reg_wr && !reg_addr && !reg_wdata[7]));

    assert_rise_clears_cnt_R8: assert property (@(posedge clk) disable iff (rst)
        (cap_in && !cap_q && ctl_bits[3] && !(reg_wr && reg_addr)) |=> (cnt_q == 8'h00));

    assert_cap_irq_on_edge_R9: assert property (@(posedge clk) disable iff (rst)
        cap_irq |-> (cap_in != cap_q));

    assert_cnt_load_R11: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr) |=> (cnt_q == $past(reg_wdata)));
endmodule

bind cap_timer cap_timer_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .cap_in    (cap_in),
    .cap_q     (cap_q),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .cnt_q     (cnt_q),
    .ovf_flag  (ovf_flag),
    .ctl_bits  (ctl_q),
    .cap_irq   (cap_irq)
);

// File: tb/cap_timer_tb_top.sv
`timescale 1ns/1ps
module cap_timer_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cap_in = 1'b0;
    logic       reg_rd = 1'b0;
    logic       reg_wr = 1'b0;
    logic       reg_addr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       ovf_irq, cap_irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    cap_timer dut_i (
        .clk       (clk),
        .rst       (rst),
        .cap_in    (cap_in),
        .reg_rd    (reg_rd),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .ovf_irq   (ovf_irq),
        .cap_irq   (cap_irq)
    );

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    // All tasks start and end just after a falling edge.
    task automatic wr(logic a, logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_mode();
        reg_rd = 1'b1; reg_addr = 1'b0;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic peek(logic a, output logic [7:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    // mode byte low bits: {ie, edge_rise, clr[1:0], rate[1:0]}
    function automatic logic [7:0] mode(logic ie, logic er, logic [1:0] clr, logic [1:0] rate);
        return {2'b00, ie, er, clr, rate};
    endfunction

    task automatic clear_flags(logic [7:0] m);
        rd_mode();
        wr(1'b0, m);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        logic [7:0] v;
        logic [7:0] m;
        bit hit;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        peek(1'b0, v); chk("R1 mode", v, 8'h00);
        peek(1'b1, v); chk("R1 cnt", v, 8'h00);
        chk("R1 irqs", {6'b0, ovf_irq, cap_irq}, 8'h00);

        // R2 rate sweep; R11 counter load
        for (int r = 0; r < 4; r++) begin
            int div;
            div = (r == 0) ? 64 : (r == 1) ? 32 : (r == 2) ? 4 : 2;
            wr(1'b0, mode(1'b0, 1'b0, 2'b01, r[1:0]));
            wr(1'b1, 8'h10);
            peek(1'b1, v); chk("R11 load", v, 8'h10);
            repeat (div * 3) @(negedge clk);
            peek(1'b1, v); chk($sformatf("R2 rate %0d", r), v, 8'h13);
        end

        // R3 wrap with capture high
        cap_in = 1'b1;
        m = mode(1'b1, 1'b0, 2'b01, 2'b11);
        wr(1'b0, m);
        wr(1'b1, 8'hFF);
        repeat (2) @(negedge clk);
        peek(1'b1, v); chk("R3 cnt wrapped", v, 8'h00);
        peek(1'b0, v); chk("R3 flags", v & 8'hC0, 8'h80);
        chk("R10 irq on", {7'b0, ovf_irq}, 8'h01);

        // R5 write 0 with no read keeps flag
        wr(1'b0, m);
        peek(1'b0, v); chk("R5 no read keeps", v & 8'hC0, 8'h80);
        // R10 enable gates interrupt
        wr(1'b0, mode(1'b0, 1'b0, 2'b01, 2'b11));
        chk("R10 irq gated", {7'b0, ovf_irq}, 8'h00);
        wr(1'b0, m);
        // R5 read then write 0 clears
        clear_flags(m);
        peek(1'b0, v); chk("R5 cleared", v & 8'hC0, 8'h00);
        chk("R10 irq off", {7'b0, ovf_irq}, 8'h00);

        // R6 writing 1 cannot set
        wr(1'b0, m | 8'hC0);
        peek(1'b0, v); chk("R6 no sw set", v, m);

        // R4 wrap with capture low
        cap_in = 1'b0;
        @(negedge clk);
        wr(1'b1, 8'hFF);
        repeat (2) @(negedge clk);
        peek(1'b0, v); chk("R4 low level", v & 8'hC0, 8'h40);
        clear_flags(m);

        // R4 free-running: capture high still sets low-level flag
        cap_in = 1'b1;
        m = mode(1'b1, 1'b0, 2'b00, 2'b11);
        wr(1'b0, m);
        wr(1'b1, 8'hFF);
        repeat (2) @(negedge clk);
        peek(1'b0, v); chk("R4 free-run", v & 8'hC0, 8'h40);

        // R7 hardware set wins over a clear in the same cycle
        rd_mode();
        hit = 1'b0;
        for (int t = 0; t < 8 && !hit; t++) begin
            wr(1'b1, 8'hFF);
            @(negedge clk);
            peek(1'b1, v);
            if (v == 8'hFF) begin
                wr(1'b0, m);
                hit = 1'b1;
            end else begin
                @(negedge clk);
            end
        end
        chk("R7 collision reached", {7'b0, hit}, 8'h01);
        peek(1'b0, v); chk("R7 set wins", v & 8'hC0, 8'h40);
        clear_flags(m);

        // R8 clear select and R9 capture interrupt sweep
        for (int c = 0; c < 4; c++) begin
            for (int dir = 0; dir < 2; dir++) begin
                for (int es = 0; es < 2; es++) begin
                    bit exp_clr;
                    wr(1'b0, mode(1'b0, es[0], c[1:0], 2'b00));
                    cap_in = ~dir[0];
                    @(negedge clk);
                    wr(1'b1, 8'h40);
                    cap_in = dir[0];
                    #1;
                    chk($sformatf("R9 irq c%0d d%0d e%0d", c, dir, es),
                        {7'b0, cap_irq}, {7'b0, (es == dir)});
                    @(negedge clk);
                    exp_clr = (c == 3) || (c == 2 && dir == 1) || (c == 1 && dir == 0);
                    peek(1'b1, v);
                    if (exp_clr)
                        chk($sformatf("R8 clear c%0d d%0d", c, dir), v, 8'h00);
                    else
                        chk($sformatf("R8 hold c%0d d%0d", c, dir),
                            {7'b0, (v == 8'h40 || v == 8'h41)}, 8'h01);
                    chk("R9 irq one cycle", {7'b0, cap_irq}, 8'h00);
                end
            end
        end

        done = 1'b1;
        finish_run();
    end
endmodule